// File: doc/BRIEF.md
# GPIO Port with Edge Capture and Interrupt

This block is a memory-mapped general-purpose I/O port of up to 32 pins, controlled through a simple synchronous register bus with a 4-bit byte address, a write strobe, 32-bit write data and registered 32-bit read data. Each pin has a direction bit, an output value bit and an interrupt enable bit. A direction bit of 1 drives the pin from the output value register. A direction bit of 0 leaves the pin as an input. The block presents the output enables and output values to an external tri-state pad, and takes the pad levels back through a two-flop synchronizer.

The interrupt trigger is chosen once at elaboration through the `TRIG` parameter. In the three edge modes, a qualifying edge on a synchronized pin sets a sticky capture bit, which software clears by writing one to it. The single interrupt line is the OR of the captured bits that are enabled. In the level mode, the interrupt line follows the OR of the enabled synchronized pin levels, and the capture register stays at zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, pin_out and pin_oe are all zero, irq is low, and the direction, enable, capture and output registers read as zero.
- R2: Address bits [3:2] select the register: 0 output value/pin level, 1 direction, 2 interrupt enable, 3 capture. Address bits [1:0] are ignored. A write takes effect at the clock edge that samples it. bus_rdata returns the selected register one clock after the address is presented.
- R3: pin_oe[i] equals direction bit i, and pin_out[i] equals output value bit i.
- R4: A read at address 0 returns the pin levels after the two-flop synchronizer, so a level applied before clock edge k can be read at bus_rdata after edge k+2.
- R5: Register bits at or above NPINS read as zero, and writes to them are ignored.
- R6: With TRIG 0 (rising), 1 (falling) or 2 (either edge), a qualifying change of the synchronized pin sets its capture bit two clock edges after the pin change is first sampled.
- R7: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged.
- R8: When an edge is detected in the same cycle as a clearing write to that bit, the capture bit remains set.
- R9: In the edge modes, irq is high while any captured bit has its enable bit set, and it stays high until every enabled captured bit is cleared.
- R10: With TRIG 3 (level-high), irq is high while any enabled synchronized pin is 1, and the capture register stays zero.
- R11: With all enable bits at zero, irq stays low in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
Register writes appear on pin_out, pin_oe and irq one clock edge after the strobe is sampled. Read data arrives one edge after its address. A pin change reaches the level read after three edges, and reaches the capture bit and irq after two edges past the first sampling edge. A behavioural model in the bench steps on the same rising edge and reproduces these latencies, and all outputs of four instances, one for each trigger mode, are compared against it at every falling edge. The directed checks place their stimulus on falling edges and count these latencies explicitly. The edge-versus-clear collision is timed so that the clearing write lands exactly in the detect cycle.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 32,
  parameter int TRIG  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam bit IS_LEVEL = (TRIG == 3);

  logic [NPINS-1:0] out_q, dir_q, en_q, cap_q;
  logic [NPINS-1:0] s1_q, s2_q, prev_q, edge_v, clr_v, wval;
  logic [1:0]       sel;
  logic [31:0]      rd_d;
  logic [1:0]       unused_addr;

  assign sel         = bus_addr[3:2];
  assign unused_addr = bus_addr[1:0];
  assign wval        = bus_wdata[NPINS-1:0];
  assign clr_v       = (bus_we && sel == 2'd3) ? wval : '0;

  generate
    if (TRIG == 0)      begin : g_rise assign edge_v = s2_q & ~prev_q; end
    else if (TRIG == 1) begin : g_fall assign edge_v = ~s2_q & prev_q; end
    else if (TRIG == 2) begin : g_both assign edge_v = s2_q ^ prev_q;  end
    else                begin : g_lvl  assign edge_v = '0;             end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      en_q  <= '0;
      cap_q <= '0;
    end else begin
      if (bus_we && sel == 2'd0) out_q <= wval;
      if (bus_we && sel == 2'd1) dir_q <= wval;
      if (bus_we && sel == 2'd2) en_q  <= wval;
      cap_q <= (cap_q & ~clr_v) | edge_v;
    end
  end

  always_comb begin
    rd_d = '0;
    case (sel)
      2'd0:    rd_d[NPINS-1:0] = s2_q;
      2'd1:    rd_d[NPINS-1:0] = dir_q;
      2'd2:    rd_d[NPINS-1:0] = en_q;
      default: rd_d[NPINS-1:0] = cap_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_d;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = IS_LEVEL ? |(s2_q & en_q) : |(cap_q & en_q);

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == 2'd1) |=> pin_oe == $past(wval));
  a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == 2'd0) |=> pin_out == $past(wval));
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && sel == 2'd2) |=> bus_rdata[NPINS-1:0] == $past(en_q));
  a_r6_edge_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v != '0) |=> ((cap_q & $past(edge_v)) == $past(edge_v)));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == 2'd3) |=> ((cap_q & $past(wval & ~edge_v)) == '0));
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [N-1:0] pin_in = 0;
  logic [31:0] rd [4];
  logic        irq_v [4];
  logic [N-1:0] po [4];
  logic [N-1:0] oe [4];

  int    n_chk = 0, n_fail = 0;
  bit    running = 0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  gpio_edge_irq #(.NPINS(N), .TRIG(0)) dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd[0]), .pin_in(pin_in),
    .pin_out(po[0]), .pin_oe(oe[0]), .irq(irq_v[0]));
  gpio_edge_irq #(.NPINS(N), .TRIG(1)) dut_fall (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd[1]), .pin_in(pin_in),
    .pin_out(po[1]), .pin_oe(oe[1]), .irq(irq_v[1]));
  gpio_edge_irq #(.NPINS(N), .TRIG(2)) dut_both (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd[2]), .pin_in(pin_in),
    .pin_out(po[2]), .pin_oe(oe[2]), .irq(irq_v[2]));
  gpio_edge_irq #(.NPINS(N), .TRIG(3)) dut_lvl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd[3]), .pin_in(pin_in),
    .pin_out(po[3]), .pin_oe(oe[3]), .irq(irq_v[3]));

  // behavioural reference model
  logic [N-1:0] m_s1, m_s2, m_prev, m_out, m_dir, m_en;
  logic [N-1:0] m_cap [4];
  logic [N-1:0] m_rd  [4];

  function automatic logic [N-1:0] edge_of(int mode, logic [N-1:0] s, logic [N-1:0] p);
    case (mode)
      0: return s & ~p;
      1: return ~s & p;
      2: return s ^ p;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [N-1:0] clr;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_dir = 0; m_en = 0;
      for (int m = 0; m < 4; m++) begin m_cap[m] = 0; m_rd[m] = 0; end
    end else begin
      clr = (bus_we && bus_addr[3:2] == 2'd3) ? bus_wdata[N-1:0] : '0;
      for (int m = 0; m < 4; m++) begin
        case (bus_addr[3:2])
          2'd0: m_rd[m] = m_s2;
          2'd1: m_rd[m] = m_dir;
          2'd2: m_rd[m] = m_en;
          default: m_rd[m] = m_cap[m];
        endcase
        m_cap[m] = (m_cap[m] & ~clr) | edge_of(m, m_s2, m_prev);
      end
      if (bus_we && bus_addr[3:2] == 2'd0) m_out = bus_wdata[N-1:0];
      if (bus_we && bus_addr[3:2] == 2'd1) m_dir = bus_wdata[N-1:0];
      if (bus_we && bus_addr[3:2] == 2'd2) m_en  = bus_wdata[N-1:0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      for (int m = 0; m < 4; m++) begin
        check({phase, " rdata"}, rd[m], {24'h0, m_rd[m]});
        check({phase, " irq"}, {31'h0, irq_v[m]},
              {31'h0, (m == 3) ? |(m_s2 & m_en) : |(m_cap[m] & m_en)});
        check({phase, " pin_out R3"}, {24'h0, po[m]}, {24'h0, m_out});
        check({phase, " pin_oe R3"}, {24'h0, oe[m]}, {24'h0, m_dir});
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_at(input logic [3:0] a);
    bus_addr = a;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (R1 run) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", {24'h0, oe[0]}, 32'h0);
    check("R1 pin_out", {24'h0, po[0]}, 32'h0);
    check("R1 irq", {31'h0, irq_v[0]}, 32'h0);
    rd_at(4'h4); check("R1 dir read", rd[0], 32'h0);
    rd_at(4'hC); check("R1 cap read", rd[0], 32'h0);

    phase = "R2 R3 R5 writes";
    wr(4'h0, 32'hFFFF_FF5A);
    wr(4'h4, 32'hFFFF_FF0F);
    check("R3 pin_out", {24'h0, po[0]}, 32'h5A);
    check("R3 pin_oe", {24'h0, oe[0]}, 32'h0F);
    rd_at(4'h4); check("R5 dir upper zero", rd[0], 32'h0000_000F);
    wr(4'h9, 32'h0000_00FF); // R2: low address bits ignored
    rd_at(4'hB); check("R2 enable read via 0xB", rd[0], 32'h0000_00FF);

    phase = "R6 R9 rising edge";
    pin_in = 8'h01;
    repeat (3) @(negedge clk);
    check("R6 rising irq", {31'h0, irq_v[0]}, 32'h1);
    check("R6 falling idle", {31'h0, irq_v[1]}, 32'h0);
    check("R6 both irq", {31'h0, irq_v[2]}, 32'h1);
    check("R10 level irq", {31'h0, irq_v[3]}, 32'h1);
    rd_at(4'h0); check("R4 pin level read", rd[0], 32'h1);
    phase = "R6 R9 falling edge";
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R6 falling irq", {31'h0, irq_v[1]}, 32'h1);
    check("R9 rising irq held", {31'h0, irq_v[0]}, 32'h1);

    phase = "R7 clear";
    wr(4'hC, 32'h0);
    check("R7 zero write keeps", {31'h0, irq_v[0]}, 32'h1);
    wr(4'hC, 32'h0000_0001);
    check("R7 rising cleared", {31'h0, irq_v[0]}, 32'h0);
    wr(4'hC, 32'hFFFF_FFFF);

    phase = "R8 edge vs clear";
    pin_in = 8'h02;
    @(negedge clk);
    @(negedge clk);
    wr(4'hC, 32'h0000_00FF);
    rd_at(4'hC); check("R8 edge wins", rd[0], 32'h0000_0002);

    phase = "R11 masked";
    wr(4'h8, 32'h0);
    check("R11 rising masked", {31'h0, irq_v[0]}, 32'h0);
    check("R11 level masked", {31'h0, irq_v[3]}, 32'h0);
    phase = "R10 level";
    wr(4'h8, 32'h0000_0002);
    check("R10 level high", {31'h0, irq_v[3]}, 32'h1);
    rd_at(4'hC); check("R10 level cap zero", rd[3], 32'h0);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 level low", {31'h0, irq_v[3]}, 32'h0);

    phase = "R4 R6 R7 mixed traffic";
    for (int i = 0; i < 600; i++) begin
      pin_in = $urandom;
      bus_addr = $urandom;
      bus_wdata = $urandom;
      bus_we = ($urandom % 4) == 0;
      @(negedge clk);
    end
    bus_we = 0;
    @(negedge clk);
    running = 0;
    summary();
    $finish;
  end
endmodule